// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Change Interrupt

This block is a register-mapped general-purpose I/O port for eight pins. Software reaches it through a small register bus with an address, write data, write and read strobes, and read data that follows the address in the same cycle. Each pin's pad is split into an input level, a driven level and an output enable. For each pin, software chooses whether it is an input or an output, whether its reading is inverted, and what level it drives from an output latch.

Any pin can raise a shared interrupt when its level changes. Software selects the comparison separately for each pin. It can be a fixed expected level, in which case the interrupt keeps coming back while the pin stays away from that level. It can also be the level the pin had in the cycle before, which catches single transitions. On the first event, the block records which pins fired and takes a snapshot of the port. Both are frozen until software reads the snapshot or the port.

Pin inputs pass through a two-stage synchronizer before any use. A pull-up mask and a configuration byte are stored and read back, but have no effect on the pins.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset, the direction register reads 0xFF (all inputs) and every other register reads 0x00. `irq` is low and `pin_oe` is 0x00.
- R2: `pin_oe` is the inverse of the direction register, so a 0 bit drives the pin. `pin_out` always equals the output latch.
- R3: A write to address 9 (port) or address 10 (latch) loads the output latch. A read of address 10 returns the latch and not the pin levels.
- R4: A read of address 9 returns the synchronized pin level XOR the polarity register (address 1). The synchronized level is `pin_in` as sampled two clock edges earlier.
- R5: A pin whose bit in the enable register (address 2) is 0 never sets a flag or raises `irq`.
- R6: When a pin's bit in the control register (address 4) is 1, the event condition is that its synchronized level differs from its bit in the default register (address 3). This condition re-raises the interrupt after each clear for as long as the mismatch lasts.
- R7: When that control bit is 0, the event condition is that the pin's synchronized level differs from its synchronized level one cycle earlier.
- R8: The flag register (address 7) and the capture register (address 8) are read-only. Writes to them have no effect.
- R9: When no interrupt is pending, an event loads the flags with the set of firing pins and loads the capture with the polarity-adjusted port value. While an interrupt is pending, neither register changes. The capture keeps its value after the clear.
- R10: A read of address 8 or 9 (with `bus_re` high) clears the flags. Any event in that same cycle is discarded.
- R11: `irq` is high exactly when the flag register is nonzero.
- R12: Address 5 (configuration) and address 6 (pull-up) store and return written bytes. Addresses 11 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for clearing reads) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive levels |
| pin_oe | output | 8 | Pad output enables |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as a one-cycle change event. The stimulus has to count the two synchronizer stages. It changes a pin on one falling edge, waits one full cycle, and then raises the read strobe, so the clear and the event arrive at the same rising edge. The bench also covers an event that arrives while an interrupt is still pending. It also covers a default-mode mismatch that re-raises the interrupt right after each clear. A behavioural model that keeps a queue of sampled pin history is checked against every output on every clock, including during a long random phase.

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_POL  = AW'(1);
  localparam logic [AW-1:0] A_IEN  = AW'(2);
  localparam logic [AW-1:0] A_DEF  = AW'(3);
  localparam logic [AW-1:0] A_CTL  = AW'(4);
  localparam logic [AW-1:0] A_CFG  = AW'(5);
  localparam logic [AW-1:0] A_PU   = AW'(6);
  localparam logic [AW-1:0] A_FLG  = AW'(7);
  localparam logic [AW-1:0] A_CAP  = AW'(8);
  localparam logic [AW-1:0] A_PORT = AW'(9);
  localparam logic [AW-1:0] A_LAT  = AW'(10);

  logic [W-1:0] dir, pol, ien, defv, ctl, cfg, pu, flg, cap, lat;
  logic [W-1:0] s1, s2, prv;
  logic [W-1:0] evt, port_val;
  logic         clr_rd;

  assign port_val = s2 ^ pol;
  assign evt      = ien & ((ctl & (s2 ^ defv)) | (~ctl & (s2 ^ prv)));
  assign clr_rd   = bus_re && (bus_addr == A_CAP || bus_addr == A_PORT);
  assign irq      = |flg;
  assign pin_out  = lat;
  assign pin_oe   = ~dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      prv <= '0;
    end else begin
      s1  <= pin_in;
      s2  <= s1;
      prv <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '1;
      pol  <= '0;
      ien  <= '0;
      defv <= '0;
      ctl  <= '0;
      cfg  <= '0;
      pu   <= '0;
      lat  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DIR:          dir  <= bus_wdata;
        A_POL:          pol  <= bus_wdata;
        A_IEN:          ien  <= bus_wdata;
        A_DEF:          defv <= bus_wdata;
        A_CTL:          ctl  <= bus_wdata;
        A_CFG:          cfg  <= bus_wdata;
        A_PU:           pu   <= bus_wdata;
        A_PORT, A_LAT:  lat  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= '0;
      cap <= '0;
    end else if (clr_rd) begin
      flg <= '0;
    end else if (!irq && |evt) begin
      flg <= evt;
      cap <= port_val;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir;
      A_POL:   bus_rdata = pol;
      A_IEN:   bus_rdata = ien;
      A_DEF:   bus_rdata = defv;
      A_CTL:   bus_rdata = ctl;
      A_CFG:   bus_rdata = cfg;
      A_PU:    bus_rdata = pu;
      A_FLG:   bus_rdata = flg;
      A_CAP:   bus_rdata = cap;
      A_PORT:  bus_rdata = port_val;
      A_LAT:   bus_rdata = lat;
      default: bus_rdata = '0;
    endcase
  end

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_PORT || bus_addr == A_LAT)) |=> (pin_out == $past(bus_wdata)));

  a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((flg & ~$past(ien)) == '0));

  a_r6_default_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((flg & $past(ctl) & ~($past(s2) ^ $past(defv))) == '0));

  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_rd) |=> ($stable(flg) && $stable(cap)));

  a_r10_clear_read: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> !irq);
endmodule

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic [7:0] pin = '0;
  logic [7:0] pout, poe;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gpio_ioc_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata),
    .pin_in(pin), .pin_out(pout), .pin_oe(poe), .irq(irq)
  );

  // behavioural reference
  logic [7:0] m_reg [0:15];
  logic [7:0] m_flg = '0, m_cap = '0;
  logic [7:0] hist [$] = '{8'h00, 8'h00, 8'h00};

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_reg[0] = 8'hFF;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
      m_reg[0] = 8'hFF;
      m_flg = '0;
      m_cap = '0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      logic [7:0] cur, old, ev;
      cur = hist[1];
      old = hist[2];
      ev = '0;
      for (int b = 0; b < 8; b++)
        if (m_reg[2][b])
          ev[b] = m_reg[4][b] ? (cur[b] != m_reg[3][b]) : (cur[b] != old[b]);
      if (re && (addr == 4'd8 || addr == 4'd9)) m_flg = '0;
      else if (m_flg == 0 && ev != 0) begin
        m_flg = ev;
        m_cap = cur ^ m_reg[1];
      end
      if (we && addr <= 4'd6) m_reg[addr] = wdata;
      if (we && (addr == 4'd9 || addr == 4'd10)) m_reg[10] = wdata;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    case (a)
      4'd7:  return m_flg;
      4'd8:  return m_cap;
      4'd9:  return hist[1] ^ m_reg[1];
      4'd10: return m_reg[10];
      default: return (a <= 4'd6) ? m_reg[a] : 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    #2;
    if (rst_n) begin
      string t;
      chk("R11 irq", {7'd0, irq}, {7'd0, m_flg != 0});
      chk("R2 pin_oe", poe, ~m_reg[0]);
      chk("R2 pin_out", pout, m_reg[10]);
      case (addr)
        4'd9:  t = "R4 port read";
        4'd10: t = "R3 latch read";
        4'd7:  t = "R8 flag read";
        4'd8:  t = "R9 capture read";
        default: t = "R12 register read";
      endcase
      chk(t, rdata, exp_rd(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; re = 1'b0;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, logic [7:0] e, string tag);
    @(negedge clk); addr = a; we = 1'b0; re = 1'b0;
    #1 chk(tag, rdata, e);
  endtask

  task automatic rdclr(logic [3:0] a);
    @(negedge clk); addr = a; re = 1'b1; we = 1'b0;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic setpin(logic [7:0] v);
    @(negedge clk); pin = v;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitc(3);
    rst_n = 1'b1;
    // R1 reset values
    peek(4'd0, 8'hFF, "R1 dir reset");
    peek(4'd7, 8'h00, "R1 flags reset");
    peek(4'd10, 8'h00, "R1 latch reset");
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
    chk("R1 oe reset", poe, 8'h00);
    // R2 R3
    wr(4'd0, 8'h0F);
    wr(4'd9, 8'hA5);
    #1 chk("R2 drive", pout, 8'hA5);
    chk("R2 enable", poe, 8'hF0);
    peek(4'd10, 8'hA5, "R3 latch via port write");
    wr(4'd10, 8'h3C);
    peek(4'd10, 8'h3C, "R3 latch write");
    // R4
    wr(4'd1, 8'hF0);
    setpin(8'h5A);
    waitc(3);
    peek(4'd9, 8'hAA, "R4 inverted read");
    // R8
    wr(4'd7, 8'hFF);
    wr(4'd8, 8'hFF);
    peek(4'd7, 8'h00, "R8 flags not written");
    peek(4'd8, 8'h00, "R8 capture not written");
    // R12
    wr(4'd5, 8'hC3);
    wr(4'd6, 8'h99);
    peek(4'd5, 8'hC3, "R12 cfg");
    peek(4'd6, 8'h99, "R12 pullup");
    peek(4'd12, 8'h00, "R12 unmapped");
    // R5 R7 R9 R10 previous-value mode
    wr(4'd1, 8'h00);
    setpin(8'h00);
    waitc(3);
    wr(4'd4, 8'h00);
    wr(4'd2, 8'h01);
    setpin(8'h02);
    waitc(5);
    chk("R5 disabled pin", {7'd0, irq}, 8'h00);
    setpin(8'h03);
    waitc(4);
    chk("R7 change raises irq", {7'd0, irq}, 8'h01);
    peek(4'd7, 8'h01, "R7 flag");
    peek(4'd8, 8'h03, "R9 capture");
    wr(4'd2, 8'h05);
    setpin(8'h07);
    waitc(4);
    peek(4'd7, 8'h01, "R9 flags held");
    peek(4'd8, 8'h03, "R9 capture held");
    rdclr(4'd8);
    #1 chk("R10 cleared", {7'd0, irq}, 8'h00);
    waitc(4);
    chk("R10 stays clear", {7'd0, irq}, 8'h00);
    peek(4'd8, 8'h03, "R9 capture kept");
    // R6 default mode
    wr(4'd2, 8'h00);
    wr(4'd3, 8'h00);
    wr(4'd4, 8'h80);
    wr(4'd2, 8'h80);
    setpin(8'h87);
    waitc(4);
    chk("R6 mismatch irq", {7'd0, irq}, 8'h01);
    peek(4'd7, 8'h80, "R6 flag");
    rdclr(4'd9);
    waitc(2);
    chk("R6 re-raise", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h80);
    rdclr(4'd8);
    waitc(3);
    chk("R6 match quiet", {7'd0, irq}, 8'h00);
    // R10 event in clear cycle is dropped
    wr(4'd4, 8'h00);
    wr(4'd2, 8'h01);
    @(negedge clk); pin = 8'h86;
    @(negedge clk);
    @(negedge clk); addr = 4'd8; re = 1'b1;
    @(negedge clk); re = 1'b0;
    waitc(4);
    chk("R10 event dropped", {7'd0, irq}, 8'h00);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      addr = 4'($urandom_range(0, 15));
      wdata = 8'($urandom);
      we = ($urandom_range(0, 3) == 0);
      re = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 2) == 0) pin = 8'($urandom);
    end
    @(negedge clk); we = 1'b0; re = 1'b0;
    waitc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule